// File: doc/BRIEF.md
# DMA Channel Control and Status Sequencer

This block is the control core of a single DMA channel. Software loads a transfer count and sets an enable level. A trigger pulse then starts a transfer sequence, and the block raises a busy flag. While the channel runs, the block tells the data path whether it may issue transfers. The data path reports each finished transfer with a completion strobe. When the last one arrives, the sequence ends and an interrupt pulse is raised.

Clearing enable in the middle of a sequence pauses the channel. Busy stays high during the pause. Setting enable again resumes from the transfers that are still outstanding, and no new trigger is needed. An abort pulse ends a sequence early and raises no interrupt.

Read or write bus errors set sticky flags, which software clears by writing ones. Any bus error halts issuing and pulses the interrupt. The channel stays halted until both flags are clear. Address generation and the bus itself live outside this block.

Top module: `dma_chan_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy, issue_ok, err_any and irq are all 0.
- R2: A trigger sampled while enable is 1, the channel is idle, no error flag is set and the loaded count is nonzero makes busy and issue_ok 1 from the next cycle.
- R3: A trigger sampled while enable is 0 is ignored, and busy stays 0.
- R4: Busy falls in the cycle after the completion strobe that finishes the loaded count. In that same cycle irq is 1 for exactly one cycle.
- R5: While busy, enable at 0 forces issue_ok to 0 and busy stays 1. Completion strobes that arrive during the pause are still counted.
- R6: Setting enable back to 1 during a pause raises issue_ok again without a trigger. The remaining count carries on from where it stopped.
- R7: Abort clears busy in the next cycle and raises no irq. Abort takes priority over a completion strobe in the same cycle.
- R8: A read-error strobe sets the read flag and a write-error strobe sets the write flag. Each flag stays set until it is cleared. err_any is 1 from the next cycle.
- R9: err_clr bit 0 clears the read flag and err_clr bit 1 clears the write flag. A set and a clear of the same flag in the same cycle leave the flag set. err_any is the OR of the two flags.
- R10: Any error strobe makes irq 1 in the next cycle. While either flag is set, issue_ok is 0 and busy keeps its value.
- R11: Triggers are ignored while either error flag is set.
- R12: cnt_load takes cnt_value only while the channel is idle. A trigger with a loaded count of 0 is ignored.
- R13: A trigger while busy is ignored and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable level |
| trig | input | 1 | Start pulse |
| cnt_load | input | 1 | Load strobe for the transfer count |
| cnt_value | input | CNT_W | Transfer count to load |
| xfer_done | input | 1 | One transfer finished |
| rd_err | input | 1 | Read bus error strobe |
| wr_err | input | 1 | Write bus error strobe |
| err_clr | input | 2 | Write-one-to-clear: bit 0 read flag, bit 1 write flag |
| abort | input | 1 | Terminate the sequence early |
| busy | output | 1 | Sequence in progress, including while paused or halted |
| issue_ok | output | 1 | The data path may issue a transfer |
| err_any | output | 1 | OR of the two error flags |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Each result is registered. busy, err_any and irq change on the first rising edge that samples the causing input. issue_ok is decoded from those registers and the enable level, so it also follows within one edge.

The bench applies each stimulus on a falling edge and reads the outputs on the next falling edge. That is exactly one rising edge later, clear of the edge itself. The irq pulse is checked for being present in that cycle and absent in the cycle after it.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int NUM_ERR = 2;
  localparam int ERR_RD  = 0;
  localparam int ERR_WR  = 1;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_BUSY = 1'b1
  } ch_state_e;
endpackage

// File: rtl/dma_seq_errflags.sv
// Sticky error flags with write-one-to-clear; a set beats a clear (R8, R9)
module dma_seq_errflags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         any_set_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[i] <= 1'b0;
      else if (set_i[i])    flag_q[i] <= 1'b1;
      else if (clr_i[i])    flag_q[i] <= 1'b0;
    end
  end

  assign flags_o   = flag_q;
  assign any_set_o = |set_i;
endmodule

// File: rtl/dma_seq_counter.sv
// Loaded count and remaining-transfer counter (R5, R6, R12)
module dma_seq_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_i,
  input  logic             cfg_load_i,
  input  logic [CNT_W-1:0] cfg_value_i,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             abort_i,
  output logic             cfg_nonzero_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cfg_q;
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cfg_q <= '0;
    else if (cfg_load_i && idle_i) cfg_q <= cfg_value_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rem_q <= '0;
    else if (abort_i)                rem_q <= '0;
    else if (start_i)                rem_q <= cfg_q;
    else if (step_i && rem_q != '0)  rem_q <= rem_q - ONE;
  end

  assign cfg_nonzero_o = (cfg_q != '0);
  assign last_o        = (rem_q == ONE);
endmodule

// File: rtl/dma_seq_ctrl.sv
// Busy state and interrupt pulse (R2, R3, R4, R7, R10, R11, R13)
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic trig_i,
  input  logic xfer_done_i,
  input  logic abort_i,
  input  logic cfg_nonzero_i,
  input  logic last_i,
  input  logic err_hold_i,
  input  logic err_new_i,
  output logic start_o,
  output logic busy_o,
  output logic irq_o
);
  ch_state_e state_q;
  logic      finish;
  logic      irq_q;

  assign start_o = (state_q == CH_IDLE) && trig_i && enable_i &&
                   !err_hold_i && cfg_nonzero_i;
  assign finish  = (state_q == CH_BUSY) && xfer_done_i && last_i && !abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= CH_IDLE;
    else if (abort_i) state_q <= CH_IDLE;
    else if (start_o) state_q <= CH_BUSY;
    else if (finish)  state_q <= CH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= finish || err_new_i;
  end

  assign busy_o = (state_q == CH_BUSY);
  assign irq_o  = irq_q;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trig,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             xfer_done,
  input  logic             rd_err,
  input  logic             wr_err,
  input  logic [1:0]       err_clr,
  input  logic             abort,
  output logic             busy,
  output logic             issue_ok,
  output logic             err_any,
  output logic             irq
);
  logic [NUM_ERR-1:0] err_set;
  logic [NUM_ERR-1:0] err_flags;
  logic               err_new;
  logic               err_hold;
  logic               start;
  logic               busy_w;
  logic               cfg_nonzero;
  logic               last;

  assign err_set[ERR_RD] = rd_err;
  assign err_set[ERR_WR] = wr_err;

  dma_seq_errflags #(.N(NUM_ERR)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (err_set),
    .clr_i     (err_clr),
    .flags_o   (err_flags),
    .any_set_o (err_new)
  );

  assign err_hold = |err_flags;

  dma_seq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .idle_i        (!busy_w),
    .cfg_load_i    (cnt_load),
    .cfg_value_i   (cnt_value),
    .start_i       (start),
    .step_i        (xfer_done && busy_w),
    .abort_i       (abort),
    .cfg_nonzero_o (cfg_nonzero),
    .last_o        (last)
  );

  dma_seq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (enable),
    .trig_i        (trig),
    .xfer_done_i   (xfer_done),
    .abort_i       (abort),
    .cfg_nonzero_i (cfg_nonzero),
    .last_i        (last),
    .err_hold_i    (err_hold),
    .err_new_i     (err_new),
    .start_o       (start),
    .busy_o        (busy_w),
    .irq_o         (irq)
  );

  assign busy     = busy_w;
  assign issue_ok = busy_w && enable && !err_hold;
  assign err_any  = err_hold;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic xfer_done,
  input logic rd_err,
  input logic wr_err,
  input logic abort,
  input logic busy,
  input logic issue_ok,
  input logic err_any,
  input logic irq
);
  p_issue_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |-> (busy && enable));

  p_issue_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> !issue_ok);

  p_no_start_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enable) |=> !busy);

  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err || wr_err) |=> err_any);

  p_err_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err || wr_err) |=> irq);

  p_fall_reason_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (irq || $past(abort)));

  p_pause_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable && !abort && !xfer_done) |=> busy);
endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .xfer_done (xfer_done),
  .rd_err    (rd_err),
  .wr_err    (wr_err),
  .abort     (abort),
  .busy      (busy),
  .issue_ok  (issue_ok),
  .err_any   (err_any),
  .irq       (irq)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  localparam int CNT_W = 8;
  localparam int NV    = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 0, trig = 0, cnt_load = 0, xfer_done = 0;
  logic rd_err = 0, wr_err = 0, abort = 0;
  logic [1:0] err_clr = '0;
  logic [CNT_W-1:0] cnt_value = '0;
  logic busy, issue_ok, err_any, irq;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  dma_chan_seq #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trig(trig),
    .cnt_load(cnt_load), .cnt_value(cnt_value), .xfer_done(xfer_done),
    .rd_err(rd_err), .wr_err(wr_err), .err_clr(err_clr), .abort(abort),
    .busy(busy), .issue_ok(issue_ok), .err_any(err_any), .irq(irq)
  );

  // Layout: tag[20:17] en trig load cnt[13:10] done rd wr clr[6:5] abort
  //         expected busy issue_ok err_any irq [3:0]
  localparam logic [20:0] VEC [NV] = '{
    {4'd12, 3'b001, 4'd3, 3'b000, 2'b00, 1'b0, 4'b0000}, // R12 load 3 idle
    {4'd3,  3'b010, 4'd0, 3'b000, 2'b00, 1'b0, 4'b0000}, // R3 trig, enable low
    {4'd3,  3'b100, 4'd0, 3'b000, 2'b00, 1'b0, 4'b0000}, // R3 enable only
    {4'd2,  3'b110, 4'd0, 3'b000, 2'b00, 1'b0, 4'b1100}, // R2 start
    {4'd13, 3'b110, 4'd0, 3'b100, 2'b00, 1'b0, 4'b1100}, // R13 trig while busy
    {4'd5,  3'b000, 4'd0, 3'b100, 2'b00, 1'b0, 4'b1000}, // R5 pause, count
    {4'd5,  3'b000, 4'd0, 3'b000, 2'b00, 1'b0, 4'b1000}, // R5 still paused
    {4'd6,  3'b100, 4'd0, 3'b000, 2'b00, 1'b0, 4'b1100}, // R6 resume
    {4'd4,  3'b100, 4'd0, 3'b100, 2'b00, 1'b0, 4'b0001}, // R4 last done
    {4'd4,  3'b100, 4'd0, 3'b000, 2'b00, 1'b0, 4'b0000}, // R4 irq gone
    {4'd12, 3'b101, 4'd2, 3'b000, 2'b00, 1'b0, 4'b0000}, // R12 load 2
    {4'd2,  3'b110, 4'd0, 3'b000, 2'b00, 1'b0, 4'b1100}, // R2 start
    {4'd12, 3'b101, 4'd5, 3'b000, 2'b00, 1'b0, 4'b1100}, // R12 load while busy
    {4'd8,  3'b100, 4'd0, 3'b010, 2'b00, 1'b0, 4'b1011}, // R8 read error
    {4'd10, 3'b110, 4'd0, 3'b000, 2'b00, 1'b0, 4'b1010}, // R10 halted
    {4'd9,  3'b100, 4'd0, 3'b000, 2'b10, 1'b0, 4'b1010}, // R9 clear write only
    {4'd9,  3'b100, 4'd0, 3'b001, 2'b01, 1'b0, 4'b1011}, // R9 wr set, rd clear
    {4'd9,  3'b100, 4'd0, 3'b000, 2'b11, 1'b0, 4'b1100}, // R9 clear both
    {4'd4,  3'b100, 4'd0, 3'b100, 2'b00, 1'b0, 4'b1100}, // R4 one left
    {4'd7,  3'b100, 4'd0, 3'b100, 2'b00, 1'b1, 4'b0000}, // R7 abort beats done
    {4'd8,  3'b100, 4'd0, 3'b001, 2'b00, 1'b0, 4'b0011}, // R8 write error idle
    {4'd11, 3'b110, 4'd0, 3'b000, 2'b00, 1'b0, 4'b0010}, // R11 trig ignored
    {4'd9,  3'b100, 4'd0, 3'b001, 2'b11, 1'b0, 4'b0011}, // R9 set wins
    {4'd9,  3'b100, 4'd0, 3'b000, 2'b11, 1'b0, 4'b0000}, // R9 cleared
    {4'd12, 3'b101, 4'd0, 3'b000, 2'b00, 1'b0, 4'b0000}, // R12 load 0
    {4'd12, 3'b110, 4'd0, 3'b000, 2'b00, 1'b0, 4'b0000}, // R12 zero trig
    {4'd12, 3'b101, 4'd1, 3'b000, 2'b00, 1'b0, 4'b0000}, // R12 load 1
    {4'd2,  3'b110, 4'd0, 3'b000, 2'b00, 1'b0, 4'b1100}, // R2 start
    {4'd4,  3'b100, 4'd0, 3'b100, 2'b00, 1'b0, 4'b0001}, // R4 single transfer
    {4'd4,  3'b100, 4'd0, 3'b000, 2'b00, 1'b0, 4'b0000}  // R4 pulse ends
  };

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {busy, issue_ok, err_any, irq};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: busy/issue/err/irq actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic idle_inputs;
    trig = 0; cnt_load = 0; xfer_done = 0; rd_err = 0; wr_err = 0;
    abort = 0; err_clr = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 4'b0000);

    for (int i = 0; i < NV; i++) begin
      enable    = VEC[i][16];
      trig      = VEC[i][15];
      cnt_load  = VEC[i][14];
      cnt_value = CNT_W'(VEC[i][13:10]);
      xfer_done = VEC[i][9];
      rd_err    = VEC[i][8];
      wr_err    = VEC[i][7];
      err_clr   = VEC[i][6:5];
      abort     = VEC[i][4];
      @(negedge clk);
      check($sformatf("R%0d step %0d", VEC[i][20:17], i), VEC[i][3:0]);
    end
    idle_inputs();

    // R7: abort while idle leaves busy low
    abort = 1;
    @(negedge clk);
    abort = 0;
    check("R7 idle abort", 4'b0000);

    // R1: reset in the middle of a halted sequence clears everything
    cnt_value = CNT_W'(4); cnt_load = 1; enable = 1;
    @(negedge clk);
    cnt_load = 0; trig = 1;
    @(negedge clk);
    trig = 0;
    check("R2 restart", 4'b1100);
    rd_err = 1;
    @(negedge clk);
    rd_err = 0;
    check("R10 halt", 4'b1011);
    rst_n = 0;
    #1;
    check("R1 async reset", 4'b0000);
    @(negedge clk);
    rst_n = 1;
    enable = 0;
    @(negedge clk);
    check("R1 released", 4'b0000);

    finish_run();
  end
endmodule